// File: doc/BRIEF.md
# Speculative Load Validity Tracker

This block keeps a small associative record of loads that a compiler has hoisted above stores whose addresses it could not prove distinct. When such an early load executes, it records the destination register tag, the access size, a load-type code and the byte address. Every later store presents its address and size, and any record whose byte range overlaps the store is dropped. When the program reaches the point where the original load stood, a check operation presents the register tag. A surviving record means the early value is still good. A missing record means the value must be fetched again.

The check comes in two flavours, selected per operation. The plain check-load flavour asks only for the single load to be reissued. The check-and-branch flavour asks for a jump to recovery code, which redoes the load and every operation that consumed it. Records can also be lost to set conflicts or to a full-table clear. A lost record always reads as a miss and never as a stale hit. The result of a check appears on the outputs one clock cycle after the check is presented.

Top module: `adv_load_tracker`

## Requirements
- R1: After reset the table holds no records, and `chk_hit_o`, `chk_reload_o`, `chk_recover_o`, `chk_size_o` and `chk_kind_o` are all low.
- R2: A check of a register whose record is present raises `chk_hit_o` in the cycle after the check. In that cycle `chk_size_o` and `chk_kind_o` carry the size code and kind code stored at allocation. Both fields are zero when there is no hit.
- R3: A check of a register with no record raises `chk_reload_o` when `chk_mode_i` is 0 (check-load) and `chk_recover_o` when `chk_mode_i` is 1 (check-and-branch). Exactly one of hit, reload and recover is high in the cycle after each check. All three are low after a cycle with no check.
- R4: A store removes every record whose byte range [addr, addr+bytes) overlaps the store's range. The byte count is 1, 2, 4 or 8 for size codes 0, 1, 2 or 3. Records that do not overlap the store stay. A record allocated in the same cycle as a store is not removed by that store.
- R5: The table has 16 records in 8 sets of 2 ways, and the set is chosen by register tag bits [2:0]. Allocation fills an empty way first, lowest way first. When both ways are full, a round-robin pointer picks the victim. The pointer starts at way 0 after reset or clear and advances only on such an eviction. An evicted register then checks as a miss.
- R6: Allocating a register that already has a record overwrites that record in place. No second record is created, and the other way of the set is left untouched.
- R7: A store and a check in the same cycle that target the same record report a miss for that check.
- R8: A check presented in the same cycle as an allocation of the same register sees the table as it was before that allocation.
- R9: The clear input empties the whole table. An allocation in the same cycle as a clear is dropped, and a check in the same cycle as a clear misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all records |
| al_valid_i | input | 1 | Early load executes this cycle |
| al_reg_i | input | 7 | Destination register tag of the early load |
| al_size_i | input | 2 | Size code of the early load (bytes = 1 << code) |
| al_kind_i | input | 2 | Load-type code to be recorded |
| al_addr_i | input | 32 | Byte address of the early load |
| st_valid_i | input | 1 | Store executes this cycle |
| st_addr_i | input | 32 | Byte address of the store |
| st_size_i | input | 2 | Size code of the store |
| chk_valid_i | input | 1 | Check operation this cycle |
| chk_reg_i | input | 7 | Register tag being checked |
| chk_mode_i | input | 1 | 0 = check-load, 1 = check-and-branch |
| chk_hit_o | output | 1 | Record present; early value is valid |
| chk_reload_o | output | 1 | Miss on a check-load; reissue the load |
| chk_recover_o | output | 1 | Miss on a check-and-branch; run recovery |
| chk_size_o | output | 2 | Recorded size code on a hit |
| chk_kind_o | output | 2 | Recorded kind code on a hit |

## Verification
The overlap rule is swept over every pair of record size and store size, with the store start moved byte by byte from eight below to eight above an aligned record. This separates touching ranges from ranges that share one byte, on both sides. Every one of the 128 register tags is allocated and checked alone, against a partner tag in the same set and against a tag in a neighbouring set, which tells the index bits apart from the stored tag bits. Short directed sequences cover the round-robin eviction order, re-allocation in place, and the same-cycle collisions of a store, an allocation or a clear with a check.

// File: rtl/adv_load_pkg.sv
package adv_load_pkg;

  typedef enum logic {
    CHK_RELOAD  = 1'b0,
    CHK_RECOVER = 1'b1
  } chk_mode_e;

  // size code -> byte count (1, 2, 4, 8)
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    size_bytes = 4'd1 << code;
  endfunction

endpackage

// File: rtl/adv_load_overlap.sv
module adv_load_overlap
  import adv_load_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [1:0]        a_size_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [1:0]        b_size_i,
  output logic              overlap_o
);

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

  // one extra bit so a range ending at the top of memory does not wrap
  always_comb begin
    a_lo      = {1'b0, a_addr_i};
    b_lo      = {1'b0, b_addr_i};
    a_hi      = a_lo + EXT_W'(size_bytes(a_size_i));
    b_hi      = b_lo + EXT_W'(size_bytes(b_size_i));
    overlap_o = (a_lo < b_hi) && (b_lo < a_hi);
  end

endmodule

// File: rtl/adv_load_set.sv
module adv_load_set
  import adv_load_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int KIND_W = 2,
  parameter int WAYS   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  alloc_en_i,
  input  logic [REG_W-1:0]      al_reg_i,
  input  logic [1:0]            al_size_i,
  input  logic [KIND_W-1:0]     al_kind_i,
  input  logic [ADDR_W-1:0]     al_addr_i,
  input  logic                  st_valid_i,
  input  logic [ADDR_W-1:0]     st_addr_i,
  input  logic [1:0]            st_size_i,
  input  logic [REG_W-1:0]      lk_reg_i,
  output logic                  lk_hit_o,
  output logic [1:0]            lk_size_o,
  output logic [KIND_W-1:0]     lk_kind_o,
  output logic [WAYS-1:0]       vld_o,
  output logic [WAYS*REG_W-1:0] tag_o
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAYS-1:0]   vld_q, vld_d;
  logic [REG_W-1:0]  tag_q  [WAYS];
  logic [1:0]        size_q [WAYS];
  logic [KIND_W-1:0] kind_q [WAYS];
  logic [ADDR_W-1:0] addr_q [WAYS];
  logic [WAY_W-1:0]  rr_q, rr_d;

  logic [WAYS-1:0] ovl, kill, alive, same, lk_match, wr;
  logic [WAY_W-1:0] victim;
  logic             use_rr;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    adv_load_overlap #(.ADDR_W(ADDR_W)) u_ovl (
      .a_addr_i  (addr_q[w]),
      .a_size_i  (size_q[w]),
      .b_addr_i  (st_addr_i),
      .b_size_i  (st_size_i),
      .overlap_o (ovl[w])
    );

    assign kill[w]     = st_valid_i & vld_q[w] & ovl[w];
    assign alive[w]    = vld_q[w] & ~kill[w];
    assign same[w]     = vld_q[w] & (tag_q[w] == al_reg_i);
    assign lk_match[w] = alive[w] & ~clear_i & (tag_q[w] == lk_reg_i);
    assign wr[w]       = alloc_en_i & ~clear_i & (victim == WAY_W'(w));

    assign tag_o[w*REG_W +: REG_W] = tag_q[w];

    // payload registers: clock-enabled, no reset needed (qualified by valid)
    always_ff @(posedge clk) begin
      if (wr[w]) begin
        tag_q[w]  <= al_reg_i;
        size_q[w] <= al_size_i;
        kind_q[w] <= al_kind_i;
        addr_q[w] <= al_addr_i;
      end
    end
  end

  // victim choice: matching tag, else lowest free way, else round-robin
  always_comb begin
    victim = rr_q;
    use_rr = ~(|same) & (&alive);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!alive[w]) victim = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (same[w]) victim = WAY_W'(w);
    end
  end

  always_comb begin
    if (clear_i) begin
      vld_d = '0;
      rr_d  = '0;
    end else begin
      vld_d = alive | wr;
      rr_d  = rr_q;
      if (alloc_en_i && use_rr) begin
        rr_d = (rr_q == LAST_WAY) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_comb begin
    lk_hit_o  = |lk_match;
    lk_size_o = '0;
    lk_kind_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_size_o = lk_size_o | size_q[w];
        lk_kind_o = lk_kind_o | kind_q[w];
      end
    end
  end

  assign vld_o = vld_q;

endmodule

// File: rtl/adv_load_tracker.sv
module adv_load_tracker
  import adv_load_pkg::*;
#(
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32,
  parameter int KIND_W  = 2,
  parameter int ENTRIES = 16,
  parameter int WAYS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              al_valid_i,
  input  logic [REG_W-1:0]  al_reg_i,
  input  logic [1:0]        al_size_i,
  input  logic [KIND_W-1:0] al_kind_i,
  input  logic [ADDR_W-1:0] al_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  input  logic              chk_mode_i,
  output logic              chk_hit_o,
  output logic              chk_reload_o,
  output logic              chk_recover_o,
  output logic [1:0]        chk_size_o,
  output logic [KIND_W-1:0] chk_kind_o
);

  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic              set_hit  [SETS];
  logic [1:0]        set_size [SETS];
  logic [KIND_W-1:0] set_kind [SETS];

  logic [SETS*WAYS-1:0]       all_vld;
  logic [SETS*WAYS*REG_W-1:0] all_tag;

  logic [IDX_W-1:0] al_idx, chk_idx;
  assign al_idx  = al_reg_i[IDX_W-1:0];
  assign chk_idx = chk_reg_i[IDX_W-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic alloc_en;
    assign alloc_en = al_valid_i & (al_idx == IDX_W'(s));

    adv_load_set #(
      .REG_W (REG_W),
      .ADDR_W(ADDR_W),
      .KIND_W(KIND_W),
      .WAYS  (WAYS)
    ) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_i),
      .alloc_en_i(alloc_en),
      .al_reg_i  (al_reg_i),
      .al_size_i (al_size_i),
      .al_kind_i (al_kind_i),
      .al_addr_i (al_addr_i),
      .st_valid_i(st_valid_i),
      .st_addr_i (st_addr_i),
      .st_size_i (st_size_i),
      .lk_reg_i  (chk_reg_i),
      .lk_hit_o  (set_hit[s]),
      .lk_size_o (set_size[s]),
      .lk_kind_o (set_kind[s]),
      .vld_o     (all_vld[s*WAYS +: WAYS]),
      .tag_o     (all_tag[s*WAYS*REG_W +: WAYS*REG_W])
    );
  end

  logic              hit_d, reload_d, recover_d;
  logic [1:0]        size_d;
  logic [KIND_W-1:0] kind_d;

  always_comb begin
    hit_d     = chk_valid_i & set_hit[chk_idx];
    reload_d  = chk_valid_i & ~hit_d & (chk_mode_e'(chk_mode_i) == CHK_RELOAD);
    recover_d = chk_valid_i & ~hit_d & (chk_mode_e'(chk_mode_i) == CHK_RECOVER);
    size_d    = hit_d ? set_size[chk_idx] : '0;
    kind_d    = hit_d ? set_kind[chk_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hit_o     <= 1'b0;
      chk_reload_o  <= 1'b0;
      chk_recover_o <= 1'b0;
      chk_size_o    <= '0;
      chk_kind_o    <= '0;
    end else begin
      chk_hit_o     <= hit_d;
      chk_reload_o  <= reload_d;
      chk_recover_o <= recover_d;
      chk_size_o    <= size_d;
      chk_kind_o    <= kind_d;
    end
  end

endmodule

// File: rtl/adv_load_tracker_chk.sv
module adv_load_tracker_chk #(
  parameter int REG_W  = 7,
  parameter int KIND_W = 2,
  parameter int NREC   = 16,
  parameter int WAYS   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              al_valid_i,
  input logic [REG_W-1:0]  al_reg_i,
  input logic [1:0]        al_size_i,
  input logic [KIND_W-1:0] al_kind_i,
  input logic              st_valid_i,
  input logic              chk_valid_i,
  input logic [REG_W-1:0]  chk_reg_i,
  input logic              chk_mode_i,
  input logic              chk_hit_o,
  input logic              chk_reload_o,
  input logic              chk_recover_o,
  input logic [1:0]        chk_size_o,
  input logic [KIND_W-1:0] chk_kind_o,
  input logic [NREC-1:0]       all_vld,
  input logic [NREC*REG_W-1:0] all_tag
);

  // R3
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_valid_i) |-> $onehot({chk_hit_o, chk_reload_o, chk_recover_o}));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chk_valid_i) |-> ({chk_hit_o, chk_reload_o, chk_recover_o} == 3'b000));

  // R3
  reload_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_reload_o |-> !$past(chk_mode_i));

  // R3
  recover_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_recover_o |-> $past(chk_mode_i));

  // R2
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_hit_o |-> (chk_size_o == 2'b00 && chk_kind_o == '0));

  // R9
  clear_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clear_i) && $past(chk_valid_i)) |-> !chk_hit_o);

  // R2
  fresh_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(al_valid_i, 2) && !$past(clear_i, 2) && $past(chk_valid_i) &&
     !$past(clear_i) && !$past(st_valid_i) &&
     ($past(chk_reg_i) == $past(al_reg_i, 2)))
    |-> (chk_hit_o && chk_size_o == $past(al_size_i, 2) &&
         chk_kind_o == $past(al_kind_i, 2)));

  // R6
  for (genvar s = 0; s < NREC / WAYS; s++) begin : g_uniq
    for (genvar a = 0; a < WAYS; a++) begin : g_a
      for (genvar b = a + 1; b < WAYS; b++) begin : g_b
        uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !(all_vld[s*WAYS+a] && all_vld[s*WAYS+b] &&
            all_tag[(s*WAYS+a)*REG_W +: REG_W] == all_tag[(s*WAYS+b)*REG_W +: REG_W]));
      end
    end
  end

endmodule

bind adv_load_tracker adv_load_tracker_chk #(
  .REG_W (REG_W),
  .KIND_W(KIND_W),
  .NREC  (ENTRIES),
  .WAYS  (WAYS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear_i      (clear_i),
  .al_valid_i   (al_valid_i),
  .al_reg_i     (al_reg_i),
  .al_size_i    (al_size_i),
  .al_kind_i    (al_kind_i),
  .st_valid_i   (st_valid_i),
  .chk_valid_i  (chk_valid_i),
  .chk_reg_i    (chk_reg_i),
  .chk_mode_i   (chk_mode_i),
  .chk_hit_o    (chk_hit_o),
  .chk_reload_o (chk_reload_o),
  .chk_recover_o(chk_recover_o),
  .chk_size_o   (chk_size_o),
  .chk_kind_o   (chk_kind_o),
  .all_vld      (all_vld),
  .all_tag      (all_tag)
);

// File: tb/adv_load_tracker_test.sv
`timescale 1ns/1ps
module adv_load_tracker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear_i, al_valid_i, st_valid_i, chk_valid_i, chk_mode_i;
  logic [6:0]  al_reg_i, chk_reg_i;
  logic [1:0]  al_size_i, al_kind_i, st_size_i;
  logic [31:0] al_addr_i, st_addr_i;
  logic        chk_hit_o, chk_reload_o, chk_recover_o;
  logic [1:0]  chk_size_o, chk_kind_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  adv_load_tracker uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .al_valid_i(al_valid_i), .al_reg_i(al_reg_i), .al_size_i(al_size_i),
    .al_kind_i(al_kind_i), .al_addr_i(al_addr_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
    .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i), .chk_mode_i(chk_mode_i),
    .chk_hit_o(chk_hit_o), .chk_reload_o(chk_reload_o), .chk_recover_o(chk_recover_o),
    .chk_size_o(chk_size_o), .chk_kind_o(chk_kind_o)
  );

  task automatic idle();
    clear_i = 0; al_valid_i = 0; st_valid_i = 0; chk_valid_i = 0; chk_mode_i = 0;
    al_reg_i = '0; chk_reg_i = '0; al_size_i = '0; al_kind_i = '0;
    st_size_i = '0; al_addr_i = '0; st_addr_i = '0;
  endtask

  task automatic cmp(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // compare the outputs produced by the check of the previous cycle
  task automatic expect_out(input string rq, input bit m, input bit eh,
                            input logic [1:0] es, input logic [1:0] ek);
    cmp(rq, "hit", chk_hit_o, eh);
    cmp(rq, "reload", chk_reload_o, !eh && !m);
    cmp(rq, "recover", chk_recover_o, !eh && m);
    cmp(rq, "size", chk_size_o, eh ? es : 2'd0);
    cmp(rq, "kind", chk_kind_o, eh ? ek : 2'd0);
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic clr();
    clear_i = 1; step();
  endtask

  task automatic al(input logic [6:0] r, input logic [1:0] sz, input logic [1:0] k,
                    input logic [31:0] a);
    al_valid_i = 1; al_reg_i = r; al_size_i = sz; al_kind_i = k; al_addr_i = a; step();
  endtask

  task automatic st(input logic [31:0] a, input logic [1:0] sz);
    st_valid_i = 1; st_addr_i = a; st_size_i = sz; step();
  endtask

  task automatic ck(input logic [6:0] r, input bit m, input bit eh,
                    input logic [1:0] es, input logic [1:0] ek, input string rq);
    chk_valid_i = 1; chk_reg_i = r; chk_mode_i = m; step();
    expect_out(rq, m, eh, es, ek);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state at the ports, and empty table
    cmp("R1", "hit", chk_hit_o, 0);
    cmp("R1", "reload", chk_reload_o, 0);
    cmp("R1", "recover", chk_recover_o, 0);
    cmp("R1", "size", chk_size_o, 0);
    for (int r = 0; r < 16; r++) ck(7'(r), 1'b0, 1'b0, 2'd0, 2'd0, "R1");

    // R2 R3: every tag alone; same-set partner and neighbour-set tag miss
    for (int r = 0; r < 128; r++) begin
      logic [6:0] t;
      t = 7'(r);
      clr();
      al(t, t[1:0], ~t[2:1], 32'h1000 + 32'(r) * 16);
      ck(t, t[0], 1'b1, t[1:0], ~t[2:1], "R2");
      ck(t ^ 7'h08, t[3], 1'b0, 2'd0, 2'd0, "R3");
      ck(t ^ 7'h01, ~t[0], 1'b0, 2'd0, 2'd0, "R3");
    end

    // R3: nothing comes out without a check
    step();
    cmp("R3", "idle", {29'd0, chk_hit_o, chk_reload_o, chk_recover_o}, 0);

    // R4: byte-range overlap sweep against an aligned record at 0x100
    for (int se = 0; se < 4; se++) begin
      for (int ss = 0; ss < 4; ss++) begin
        for (int off = -8; off <= 8; off++) begin
          bit ov;
          ov = (off < (1 << se)) && (off + (1 << ss) > 0);
          clr();
          al(7'd21, 2'(se), 2'd1, 32'h100);
          st(32'(32'sh100 + off), 2'(ss));
          ck(7'd21, 1'b1, !ov, 2'(se), 2'd1, "R4");
        end
      end
    end

    // R4: a store in the allocation cycle leaves the new record
    clr();
    al_valid_i = 1; al_reg_i = 7'd9; al_size_i = 2'd3; al_kind_i = 2'd2; al_addr_i = 32'h200;
    st_valid_i = 1; st_addr_i = 32'h200; st_size_i = 2'd3;
    step();
    ck(7'd9, 1'b0, 1'b1, 2'd3, 2'd2, "R4");

    // R5: all 16 records fit, one per set per way
    clr();
    for (int r = 0; r < 16; r++) al(7'(r), 2'd2, 2'(r), 32'h4000 + 32'(r) * 8);
    for (int r = 0; r < 16; r++) ck(7'(r), 1'b0, 1'b1, 2'd2, 2'(r), "R5");

    // R5: round-robin eviction in set 3
    clr();
    al(7'd3,  2'd0, 2'd0, 32'h10);
    al(7'd11, 2'd0, 2'd1, 32'h20);
    al(7'd19, 2'd0, 2'd2, 32'h30);   // evicts way0 (tag 3)
    ck(7'd3,  1'b1, 1'b0, 2'd0, 2'd0, "R5");
    ck(7'd11, 1'b0, 1'b1, 2'd0, 2'd1, "R5");
    ck(7'd19, 1'b0, 1'b1, 2'd0, 2'd2, "R5");
    al(7'd27, 2'd0, 2'd3, 32'h40);   // evicts way1 (tag 11)
    ck(7'd11, 1'b0, 1'b0, 2'd0, 2'd0, "R5");
    ck(7'd19, 1'b0, 1'b1, 2'd0, 2'd2, "R5");
    ck(7'd27, 1'b0, 1'b1, 2'd0, 2'd3, "R5");

    // R6: re-allocation overwrites in place and spares the partner
    clr();
    al(7'd4,  2'd1, 2'd0, 32'h800);
    al(7'd12, 2'd1, 2'd1, 32'h900);
    al(7'd4,  2'd2, 2'd3, 32'hA00);
    ck(7'd12, 1'b0, 1'b1, 2'd1, 2'd1, "R6");
    ck(7'd4,  1'b0, 1'b1, 2'd2, 2'd3, "R6");
    st(32'h800, 2'd1);               // old range of tag 4: no effect now
    ck(7'd4,  1'b0, 1'b1, 2'd2, 2'd3, "R6");
    al(7'd20, 2'd0, 2'd0, 32'hB00);  // both ways free of 20: must evict, not duplicate
    ck(7'd20, 1'b0, 1'b1, 2'd0, 2'd0, "R6");
    st(32'hA02, 2'd0);
    ck(7'd4,  1'b1, 1'b0, 2'd0, 2'd0, "R6");

    // R7: store and check of the same record in one cycle
    clr();
    al(7'd30, 2'd2, 2'd1, 32'h300);
    st_valid_i = 1; st_addr_i = 32'h303; st_size_i = 2'd0;
    chk_valid_i = 1; chk_reg_i = 7'd30; chk_mode_i = 1'b1;
    step();
    expect_out("R7", 1'b1, 1'b0, 2'd0, 2'd0);
    ck(7'd30, 1'b0, 1'b0, 2'd0, 2'd0, "R7");

    // R8: check in the allocation cycle sees the old table
    clr();
    al_valid_i = 1; al_reg_i = 7'd45; al_size_i = 2'd1; al_kind_i = 2'd2; al_addr_i = 32'h600;
    chk_valid_i = 1; chk_reg_i = 7'd45; chk_mode_i = 1'b0;
    step();
    expect_out("R8", 1'b0, 1'b0, 2'd0, 2'd0);
    ck(7'd45, 1'b0, 1'b1, 2'd1, 2'd2, "R8");

    // R9: clear empties everything, drops a same-cycle allocation, misses a same-cycle check
    for (int r = 0; r < 16; r++) al(7'(r + 64), 2'd3, 2'd1, 32'h7000 + 32'(r) * 8);
    clear_i = 1;
    al_valid_i = 1; al_reg_i = 7'd100; al_size_i = 2'd0; al_kind_i = 2'd0; al_addr_i = 32'h50;
    chk_valid_i = 1; chk_reg_i = 7'd64; chk_mode_i = 1'b1;
    step();
    expect_out("R9", 1'b1, 1'b0, 2'd0, 2'd0);
    for (int r = 0; r < 16; r++) ck(7'(r + 64), 1'b0, 1'b0, 2'd0, 2'd0, "R9");
    ck(7'd100, 1'b1, 1'b0, 2'd0, 2'd0, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule